// File: doc/BRIEF.md
# SPI Master Clock and Select-Lead Generator

This block produces the serial clock and the select-to-clock timing for one SPI master frame. A start request captures an 8-bit clock divisor, picks one of four active-low peripheral selects, asserts that select, waits a lead interval, toggles the serial clock through one 8-bit frame and then releases the select. The clock runs at the system clock divided by twice the divisor. The lead interval is chosen per transfer. It is either the programmed 7-bit lead field counted in system clocks, or half a serial-clock period.

A single enable input gates all activity. While it is low the block stays idle and the pin drive-enable output is low, so the pins can serve other uses. A divisor below 2 switches the clock generator off, and in that case a start is refused. The frame shifter is a plain mode-0 shifter, MSB first. Its purpose is to give the timing a real frame to check against.

Top module: `spi_lead_clkgen`

## Requirements
- R1: While a frame runs, the time between successive SCK transitions is exactly `divisor` system clocks, so one SCK period is 2 × `divisor` clocks.
- R2: A `divisor` of 0 or 1 turns the clock off. A start is then ignored: `busy` stays 0, SCK stays low, every `pcs_n` bit stays 1 and `done` never pulses.
- R3: With `lead_sel` = 1 and `lead_cnt` in 1..127, the first SCK rising edge comes `lead_cnt` system clocks after the select goes low.
- R4: With `lead_sel` = 1 and `lead_cnt` = 0, the lead is 128 system clocks.
- R5: With `lead_sel` = 0, `lead_cnt` has no effect and the lead equals `divisor` system clocks, which is half an SCK period.
- R6: `pins_oe` follows `enable` one clock later. While `enable` is low, a start is ignored. If `enable` drops mid-frame, the next clock forces `busy` to 0, all selects high and SCK low, and `done` does not pulse.
- R7: `cs_sel` (0..3) picks which `pcs_n` bit goes low (bit index = `cs_sel`). Exactly one bit is low while `busy` is 1, and all bits are high while it is 0.
- R8: SCK idles low and each frame has 8 rising and 8 falling edges. `mosi` presents `tx_data` MSB first and changes only on falling edges. `miso` is sampled on rising edges, and the first sampled bit ends up in `rx_data[7]`.
- R9: One system clock after the last (falling) SCK edge, the select goes high, `busy` falls and `done` is 1 for exactly one clock.
- R10: A start while `busy` is 1 is ignored. Changes to `divisor`, `lead_cnt`, `lead_sel`, `cs_sel` or `tx_data` during a frame take effect only at the next accepted start.
- R11: After reset, SCK is 0, all `pcs_n` bits are 1, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle and releases the pins |
| divisor | input | 8 | Half-period of SCK in system clocks; values below 2 switch SCK off |
| lead_cnt | input | 7 | Programmed select-to-SCK lead in system clocks (0 means 128) |
| lead_sel | input | 1 | Per-transfer choice: 1 = programmed lead, 0 = half-period lead |
| cs_sel | input | 2 | Index of the select to assert for this transfer |
| start | input | 1 | Request one frame; sampled only when idle |
| tx_data | input | 8 | Frame to shift out, MSB first |
| miso | input | 1 | Serial data from the peripheral |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| pcs_n | output | 4 | Active-low peripheral selects |
| rx_data | output | 8 | Frame shifted in, valid when `done` pulses |
| busy | output | 1 | A frame is in progress (lead, shift or tail) |
| done | output | 1 | One-clock pulse at frame end |
| pins_oe | output | 1 | Pin drive enable, registered copy of `enable` |

## Verification
On every cycle the assertions check the cycle-level invariants. SCK is low while idle. Exactly one select is low while busy, and all are released while idle. `done` lasts a single clock and never coincides with busy. A refused start (divisor below 2 or enable low) leaves the block idle, and `pins_oe` tracks `enable`. The lengths of the lead and of each half-period, the edge count, the bit order on `mosi` and `rx_data`, the one-clock tail and the freezing of the configuration while busy span many cycles and depend on the settings. The bench's scoreboard shows these by timing every transfer against the expected item queued by its driver.

// File: rtl/spi_lead_pkg.sv
package spi_lead_pkg;
  // Frame phases: idle, select-to-clock lead, clock toggling, one-cycle tail
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spi_phase_e;
endpackage

// File: rtl/spi_tick_counter.sv
// Loadable down-counter shared by the lead interval and the half-period timer.
module spi_tick_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/spi_frame_shifter.sv
// Mode-0 frame shifter: out on falling edges, in on rising edges, MSB first.
module spi_frame_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            rise_evt,
  input  logic            fall_evt,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_data
);
  logic [BITS-1:0] tx_q, tx_d;
  logic [BITS-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load) begin
      tx_d = load_data;
    end else if (fall_evt) begin
      tx_d = {tx_q[BITS-2:0], 1'b0};
    end
  end

  always_comb begin
    rx_d = rx_q;
    if (rise_evt) begin
      rx_d = {rx_q[BITS-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[BITS-1];
  assign rx_data = rx_q;
endmodule

// File: rtl/spi_cs_decode.sv
// Holds the chosen select index for a frame and drives the active-low selects.
module spi_cs_decode #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              active_d,
  output logic [NUM_CS-1:0] pcs_n
);
  logic [SEL_W-1:0]  sel_q;
  logic [SEL_W-1:0]  sel_nxt;
  logic [NUM_CS-1:0] pcs_d;
  logic [NUM_CS-1:0] pcs_q;

  assign sel_nxt = load ? sel_in : sel_q;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign pcs_d[i] = ~(active_d && (sel_nxt == SEL_W'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      pcs_q <= '1;
    end else begin
      sel_q <= sel_nxt;
      pcs_q <= pcs_d;
    end
  end

  assign pcs_n = pcs_q;
endmodule

// File: rtl/spi_lead_clkgen.sv
module spi_lead_clkgen
  import spi_lead_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int LEAD_W     = 7,
  parameter int NUM_CS     = 4,
  parameter int SEL_W      = $clog2(NUM_CS),
  parameter int FRAME_BITS = 8,
  parameter int DIV_RST    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [DIV_W-1:0]      divisor,
  input  logic [LEAD_W-1:0]     lead_cnt,
  input  logic                  lead_sel,
  input  logic [SEL_W-1:0]      cs_sel,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_data,
  input  logic                  miso,
  output logic                  sck,
  output logic                  mosi,
  output logic [NUM_CS-1:0]     pcs_n,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  busy,
  output logic                  done,
  output logic                  pins_oe
);
  localparam int EDGES  = 2 * FRAME_BITS;
  localparam int EDGE_W = $clog2(EDGES + 1);
  localparam int CNT_W  = (DIV_W > LEAD_W) ? DIV_W : LEAD_W;

  spi_phase_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              done_q, done_d;
  logic              oe_q;

  logic              go;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_val;
  logic              cnt_zero;
  logic              sck_evt;
  logic [LEAD_W-1:0] lead_m1;

  // A zero lead field wraps to all ones, i.e. 2**LEAD_W clocks of lead
  assign lead_m1 = lead_cnt - LEAD_W'(1);
  assign go      = (state_q == ST_IDLE) && start && enable && (divisor > DIV_W'(1));
  assign sck_evt = ((state_q == ST_LEAD) || (state_q == ST_SHIFT)) && cnt_zero;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    sck_d    = sck_q;
    edge_d   = edge_q;
    div_d    = div_q;
    done_d   = 1'b0;
    cnt_load = 1'b0;
    cnt_val  = CNT_W'(div_q - DIV_W'(1));
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d  = ST_LEAD;
          div_d    = divisor;
          edge_d   = '0;
          cnt_load = 1'b1;
          cnt_val  = lead_sel ? CNT_W'(lead_m1) : CNT_W'(divisor - DIV_W'(1));
        end
      end
      ST_LEAD, ST_SHIFT: begin
        if (sck_evt) begin
          sck_d    = ~sck_q;
          cnt_load = 1'b1;
          edge_d   = edge_q + EDGE_W'(1);
          state_d  = (edge_q == EDGE_W'(EDGES - 1)) ? ST_TAIL : ST_SHIFT;
        end
      end
      ST_TAIL: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!enable) begin
      state_d  = ST_IDLE;
      sck_d    = 1'b0;
      done_d   = 1'b0;
      cnt_load = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      edge_q  <= '0;
      div_q   <= DIV_W'(DIV_RST);
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      edge_q  <= edge_d;
      div_q   <= div_d;
      done_q  <= done_d;
      oe_q    <= enable;
    end
  end

  spi_tick_counter #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .cnt_zero (cnt_zero)
  );

  spi_frame_shifter #(.BITS(FRAME_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (go),
    .load_data (tx_data),
    .rise_evt  (sck_evt && !sck_q),
    .fall_evt  (sck_evt && sck_q),
    .miso      (miso),
    .mosi      (mosi),
    .rx_data   (rx_data)
  );

  spi_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .sel_in   (cs_sel),
    .active_d (state_d != ST_IDLE),
    .pcs_n    (pcs_n)
  );

  assign sck     = sck_q;
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;
  assign pins_oe = oe_q;
endmodule

// File: rtl/spi_lead_clkgen_chk.sv
module spi_lead_clkgen_chk #(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              start,
  input logic [DIV_W-1:0]  divisor,
  input logic              sck,
  input logic              busy,
  input logic              done,
  input logic              pins_oe,
  input logic [NUM_CS-1:0] pcs_n
);
  assert_idle_sck_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(~pcs_n) == 1));

  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&pcs_n));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_slow_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (divisor < DIV_W'(2))) |=> !busy);

  assert_disable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !pins_oe && !done));

  assert_enable_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> pins_oe);

  assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind spi_lead_clkgen spi_lead_clkgen_chk #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .start   (start),
  .divisor (divisor),
  .sck     (sck),
  .busy    (busy),
  .done    (done),
  .pins_oe (pins_oe),
  .pcs_n   (pcs_n)
);

// File: tb/tb_spi_lead_clkgen.sv
module tb_spi_lead_clkgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [7:0] divisor;
  logic [6:0] lead_cnt;
  logic       lead_sel;
  logic [1:0] cs_sel;
  logic       start;
  logic [7:0] tx_data;
  logic       miso;
  logic       sck, mosi, busy, done, pins_oe;
  logic [3:0] pcs_n;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  spi_lead_clkgen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .divisor(divisor),
    .lead_cnt(lead_cnt), .lead_sel(lead_sel), .cs_sel(cs_sel), .start(start),
    .tx_data(tx_data), .miso(miso), .sck(sck), .mosi(mosi), .pcs_n(pcs_n),
    .rx_data(rx_data), .busy(busy), .done(done), .pins_oe(pins_oe)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct {
    int         lead;
    string      lead_req;
    int         half;
    int         cs;
    logic [7:0] tx;
    logic [7:0] rx;
    bit         abort;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] rx_pat;
  int         midx;
  logic       mprev;

  // Peripheral model: next bit after each falling SCK edge
  always @(negedge clk) begin
    if (busy) begin
      if (mprev && !sck) begin
        midx = midx + 1;
        if (midx < 8) miso = rx_pat[7-midx];
      end
      mprev = sck;
    end else begin
      mprev = 1'b0;
    end
  end

  // Monitor: times each frame and compares with the queued expectation
  initial begin
    bit   prev_busy = 0, prev_sck = 0, check_next = 0;
    int   c = 0, first_rise = -1, last_edge = -1, rises = 0, falls = 0, bad_half = 0, cs_seen = 0;
    logic [7:0] mo = 0;
    exp_t cur;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        prev_busy = 0; prev_sck = 0; check_next = 0;
        continue;
      end
      if (check_next) begin
        chk("R9", "done lasts one clock", done, 0);
        check_next = 0;
      end
      if (busy && !prev_busy) begin
        c = 0; first_rise = -1; last_edge = -1; rises = 0; falls = 0; bad_half = 0; mo = 0;
        cs_seen = -1;
        for (int i = 0; i < 4; i++) if (!pcs_n[i]) cs_seen = i;
        if (exp_q.size() == 0) begin
          chk("R10", "unexpected frame start", 1, 0);
          cur = '{0, "R10", 0, 0, 8'h00, 8'h00, 1'b1};
        end else begin
          cur = exp_q.pop_front();
        end
      end else if (busy) begin
        c++;
      end
      if (busy && (sck != prev_sck)) begin
        if (sck) begin
          rises++;
          if (first_rise < 0) first_rise = c;
          mo = {mo[6:0], mosi};
        end else begin
          falls++;
        end
        if (last_edge >= 0 && (c - last_edge) != cur.half) bad_half++;
        last_edge = c;
      end
      if (!busy && prev_busy) begin
        if (cur.abort) begin
          chk("R6", "done after abort", done, 0);
          chk("R6", "selects after abort", pcs_n, 15);
          chk("R6", "sck after abort", sck, 0);
        end else begin
          chk(cur.lead_req, "lead clocks", first_rise, cur.lead);
          chk("R1", "mistimed half periods", bad_half, 0);
          chk("R8", "rising edges", rises, 8);
          chk("R8", "falling edges", falls, 8);
          chk("R8", "mosi frame", mo, cur.tx);
          chk("R8", "rx_data", rx_data, cur.rx);
          chk("R7", "select index", cs_seen, cur.cs);
          chk("R9", "tail clocks", c + 1 - last_edge, 1);
          chk("R9", "done at end", done, 1);
          chk("R9", "selects released", pcs_n, 15);
          check_next = 1;
        end
      end
      prev_busy = busy;
      prev_sck  = sck;
    end
  end

  // Driver: queue the expectation, request one frame, optionally disturb or abort it
  task automatic run(int div, int lead, bit flag, int cs, logic [7:0] tx, logic [7:0] rx,
                     int disturb_at, int abort_at);
    exp_t e;
    int n;
    @(negedge clk);
    divisor = 8'(div); lead_cnt = 7'(lead); lead_sel = flag; cs_sel = 2'(cs);
    tx_data = tx; rx_pat = rx; midx = 0; miso = rx[7]; enable = 1'b1;
    e.lead     = flag ? ((lead == 0) ? 128 : lead) : div;
    e.lead_req = flag ? ((lead == 0) ? "R4" : "R3") : "R5";
    e.half = div; e.cs = cs; e.tx = tx; e.rx = rx; e.abort = (abort_at > 0);
    exp_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (busy) begin
      @(negedge clk);
      n++;
      if (n == disturb_at) begin
        divisor = 8'd2; lead_cnt = 7'd3; lead_sel = ~flag; cs_sel = 2'(cs ^ 1);
        tx_data = ~tx; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (n == abort_at) enable = 1'b0;
    end
    @(negedge clk);
    start = 1'b0; enable = 1'b1;
  endtask

  task automatic refused(string req);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(req, "busy after refused start", busy, 0);
      chk(req, "selects after refused start", pcs_n, 15);
      chk(req, "sck after refused start", sck, 0);
      chk(req, "done after refused start", done, 0);
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL R9 watchdog expired: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; divisor = 8'd4; lead_cnt = 7'd0; lead_sel = 1'b0;
    cs_sel = 2'd0; start = 1'b0; tx_data = 8'h00; miso = 1'b0; rx_pat = 8'h00;
    midx = 0; mprev = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "sck in reset", sck, 0);
    chk("R11", "selects in reset", pcs_n, 15);
    chk("R11", "busy in reset", busy, 0);
    chk("R11", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", "busy after reset", busy, 0);

    // R6 enable gating
    enable = 1'b0;
    @(negedge clk);
    chk("R6", "pins_oe while disabled", pins_oe, 0);
    refused("R6");
    enable = 1'b1;
    @(negedge clk);
    chk("R6", "pins_oe once enabled", pins_oe, 1);

    // R5 half-period lead, field ignored; R1, R8, R7
    run(4, 9, 1'b0, 0, 8'hA5, 8'h3C, 0, 0);
    // R3 shortest and longest programmed lead
    run(2, 1, 1'b1, 3, 8'h81, 8'h7E, 0, 0);
    run(3, 127, 1'b1, 1, 8'h5A, 8'hC3, 0, 0);
    // R4 zero field means 128
    run(5, 0, 1'b1, 2, 8'hF0, 8'h0F, 0, 0);
    // R1 largest divisor
    run(255, 2, 1'b0, 1, 8'h69, 8'h96, 0, 0);

    // R2 divisor of 0 and 1 refuse the start
    divisor = 8'd0; refused("R2");
    divisor = 8'd1; refused("R2");

    // R10 start and configuration changes mid-frame are ignored, then used next time
    run(6, 20, 1'b1, 1, 8'hC6, 8'h39, 10, 0);
    run(2, 3, 1'b1, 0, 8'h39, 8'hE1, 0, 0);

    // R6 abort on enable drop
    run(4, 5, 1'b1, 2, 8'hFF, 8'h00, 30, 0 + 30);
    chk("R6", "pins_oe restored", pins_oe, 0);
    @(negedge clk);
    chk("R6", "pins_oe after re-enable", pins_oe, 1);
    run(3, 4, 1'b1, 3, 8'h12, 8'h34, 0, 0);

    repeat (5) @(negedge clk);
    chk("R10", "frames left unseen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule